// File: doc/BRIEF.md
# Byte-wide SUBLEQ processor core

This block is a tiny one-instruction computer. Its only operation subtracts one memory cell from another, writes the difference back and branches when the outcome is zero or negative. Program and data live together in one writable store of 32 eight-bit cells. A running program may therefore alter its own operand bytes, and every such change is seen by the next fetch of the altered instruction.

Before a run, a host fills memory through a load port and then pulses a start strobe. The core steps through instructions from address 0 until the program counter reaches the top cell, address 31. At that point it raises a halt flag that stays set until reset. An instruction counter shows how many instructions completed. Once the core has stopped, a read port returns cell contents, so results can be compared against a behavioural model.

Top module: `subleq_core`

## Requirements
- R1: An instruction is three consecutive cells at PC, PC+1 and PC+2 that hold operand addresses A, B and C. Executing it stores (M[B] - M[A]) mod 256 into cell B.
- R2: The new M[B] is read as a two's-complement byte. If it is 0 or in the range 128..255, PC becomes C. Otherwise PC becomes PC+3 modulo 32.
- R3: When PC equals 31 the core halts instead of fetching. Address 31 is never executed. The halt flag then stays 1 until reset, and a start strobe while halted has no effect on the flag, the counter or memory.
- R4: Only the low 5 bits of each operand byte are used as an address, so every byte value maps onto a cell. For example, 52 selects cell 20 and 63 selects cell 31.
- R5: A write to a cell that holds an operand of some instruction is used by the next fetch of that instruction. A self-modifying program therefore ends with exactly the memory image that sequential execution produces.
- R6: The instruction counter is 0 after reset and increases by exactly one for each completed instruction.
- R7: The load port (ld_en, ld_addr, ld_data) writes memory only between reset and start. Loads issued while running or halted change no cell.
- R8: Whenever the core is not running, rd_data shows M[rd_addr] one clock after rd_addr is presented.
- R9: After reset, halted is 0, the counter is 0 and the first start begins execution at address 0.
- R10: A start strobe while running has no effect on the sequence of instructions.
- R11: Each instruction takes exactly 7 clock cycles. If the program halts after N instructions, halted is first 1 after the (1+7N)-th rising edge, counting the edge that samples start as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at address 0 (one-cycle strobe) |
| ld_en | input | 1 | Load-port write enable (before start only) |
| ld_addr | input | 5 | Load-port cell address |
| ld_data | input | 8 | Load-port write data |
| rd_addr | input | 5 | Read-port cell address |
| rd_data | output | 8 | Cell contents, one cycle after rd_addr |
| halted | output | 1 | Set once PC reaches 31, held until reset |
| instr_count | output | 16 | Number of completed instructions |

## Verification
Memory on the read port is due one clock after its address is presented. The halt flag is due 1+7N edges after the edge that samples start, where N is the instruction count the bench's own model predicts. The bench drives every input on the falling edge and samples outputs on the next falling edge. It counts rising edges from the start strobe, so both the halt timing and the final memory image are compared at the exact cycle they become valid.

// File: rtl/subleq_pkg.sv
package subleq_pkg;
    parameter int ADDR_W = 5;
    parameter int DATA_W = 8;
    parameter int CNT_W  = 16;
    parameter int DEPTH  = 1 << ADDR_W;
    parameter logic [ADDR_W-1:0] HALT_ADDR = ADDR_W'(DEPTH - 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FA,
        ST_FB,
        ST_FC,
        ST_RA,
        ST_RB,
        ST_WB,
        ST_UPD,
        ST_HALT
    } step_e;

    typedef struct packed {
        step_e             state;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] opa;
        logic [ADDR_W-1:0] opb;
        logic [ADDR_W-1:0] opc;
        logic [DATA_W-1:0] va;
        logic [DATA_W-1:0] diff;
        logic              leq;
        logic [CNT_W-1:0]  count;
    } core_regs_t;
endpackage

// File: rtl/subleq_mem.sv
module subleq_mem
    import subleq_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    // Single port, read-first, one cycle of read latency.
    always_ff @(posedge clk) begin
        if (we) begin
            cells_q[addr] <= wdata;
        end
        rdata_q <= cells_q[addr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/subleq_alu.sv
module subleq_alu
    import subleq_pkg::*;
(
    input  logic [DATA_W-1:0] minuend,
    input  logic [DATA_W-1:0] subtrahend,
    output logic [DATA_W-1:0] diff,
    output logic              leq
);
    always_comb begin
        diff = minuend - subtrahend;
        leq  = (diff == '0) || diff[DATA_W-1];
    end
endmodule

// File: rtl/subleq_ctrl.sv
module subleq_ctrl
    import subleq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              halted,
    output logic [CNT_W-1:0]  count
);
    core_regs_t        r_q, r_d;
    logic [DATA_W-1:0] alu_diff;
    logic              alu_leq;
    logic [ADDR_W-1:0] pc_next;

    subleq_alu u_alu (
        .minuend   (mem_rdata),
        .subtrahend(r_q.va),
        .diff      (alu_diff),
        .leq       (alu_leq)
    );

    always_comb begin
        r_d       = r_q;
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        pc_next   = r_q.leq ? r_q.opc : r_q.pc + ADDR_W'(3);
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state = (r_q.pc == HALT_ADDR) ? ST_HALT : ST_FA;
                end
            end
            ST_FA: begin
                mem_addr  = r_q.pc;
                r_d.state = ST_FB;
            end
            ST_FB: begin
                r_d.opa   = mem_rdata[ADDR_W-1:0];
                mem_addr  = r_q.pc + ADDR_W'(1);
                r_d.state = ST_FC;
            end
            ST_FC: begin
                r_d.opb   = mem_rdata[ADDR_W-1:0];
                mem_addr  = r_q.pc + ADDR_W'(2);
                r_d.state = ST_RA;
            end
            ST_RA: begin
                r_d.opc   = mem_rdata[ADDR_W-1:0];
                mem_addr  = r_q.opa;
                r_d.state = ST_RB;
            end
            ST_RB: begin
                r_d.va    = mem_rdata;
                mem_addr  = r_q.opb;
                r_d.state = ST_WB;
            end
            ST_WB: begin
                mem_addr  = r_q.opb;
                mem_we    = 1'b1;
                mem_wdata = alu_diff;
                r_d.diff  = alu_diff;
                r_d.leq   = alu_leq;
                r_d.state = ST_UPD;
            end
            ST_UPD: begin
                r_d.pc    = pc_next;
                r_d.count = r_q.count + CNT_W'(1);
                r_d.state = (pc_next == HALT_ADDR) ? ST_HALT : ST_FA;
            end
            ST_HALT: begin
                r_d.state = ST_HALT;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy   = (r_q.state != ST_IDLE) && (r_q.state != ST_HALT);
    assign halted = (r_q.state == ST_HALT);
    assign count  = r_q.count;

    // R3: once halted, stays halted
    p_halt_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R3: the halt address is never fetched
    p_no_fetch_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_FA) |-> (r_q.pc != HALT_ADDR));

    // R2: a zero-or-negative result loads C into the PC
    p_pc_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_UPD && r_q.leq) |=> (r_q.pc == $past(r_q.opc)));

    // R6: the counter only ever steps by one
    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.count != $past(r_q.count)) |-> (r_q.count == $past(r_q.count) + CNT_W'(1)));

    // R11: a fetch always continues through the fixed sequence
    p_fetch_seq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_FA) |=> (r_q.state == ST_FB));
endmodule

// File: rtl/subleq_core.sv
module subleq_core
    import subleq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              halted,
    output logic [CNT_W-1:0]  instr_count
);
    logic [ADDR_W-1:0] ctrl_addr;
    logic              ctrl_we;
    logic [DATA_W-1:0] ctrl_wdata;
    logic              busy;
    logic              idle;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;

    subleq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mem_rdata(mem_rdata),
        .mem_addr (ctrl_addr),
        .mem_we   (ctrl_we),
        .mem_wdata(ctrl_wdata),
        .busy     (busy),
        .halted   (halted),
        .count    (instr_count)
    );

    // Memory port arbitration: the core owns it while running, the load
    // port before start, the read port otherwise.
    always_comb begin
        idle = !busy && !halted;
        if (busy) begin
            mem_addr  = ctrl_addr;
            mem_we    = ctrl_we;
            mem_wdata = ctrl_wdata;
        end else if (ld_en && idle) begin
            mem_addr  = ld_addr;
            mem_we    = 1'b1;
            mem_wdata = ld_data;
        end else begin
            mem_addr  = rd_addr;
            mem_we    = 1'b0;
            mem_wdata = '0;
        end
    end

    subleq_mem u_mem (
        .clk  (clk),
        .we   (mem_we),
        .addr (mem_addr),
        .wdata(mem_wdata),
        .rdata(mem_rdata)
    );

    assign rd_data = mem_rdata;

    // R7: no memory write once the core has halted
    p_halt_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    // R7: a load request while running never reaches the memory
    p_run_load_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ld_en && !ctrl_we) |-> !mem_we);
endmodule

// File: tb/subleq_core_test.sv
`timescale 1ns/1ps
module subleq_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       ld_en = 1'b0;
    logic [4:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic [4:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       halted;
    logic [15:0] instr_count;

    int tests = 0;
    int fails = 0;
    int prog [32];
    int model [32];
    int model_n;
    int edges;
    bit wd_expired = 0;

    always #2.5 clk = ~clk;

    subleq_core uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .halted(halted), .instr_count(instr_count)
    );

    // {va, vb} pairs for the single-subtraction program
    localparam logic [15:0] VEC [10] = '{
        {8'd3,   8'd5},   {8'd5,   8'd5},   {8'd6,   8'd5},
        {8'd0,   8'd127}, {8'd0,   8'd128}, {8'd255, 8'd0},
        {8'd1,   8'd129}, {8'd128, 8'd0},   {8'd129, 8'd0},
        {8'd200, 8'd73}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference built from R1, R2, R4
    task automatic run_model();
        int pc = 0;
        model_n = 0;
        for (int i = 0; i < 32; i++) model[i] = prog[i] & 255;
        while (pc != 31 && model_n < 5000) begin
            int a = model[pc] & 31;
            int b = model[(pc + 1) % 32] & 31;
            int c = model[(pc + 2) % 32] & 31;
            int r = (model[b] - model[a]) & 255;
            model[b] = r;
            pc = (r == 0 || r >= 128) ? c : (pc + 3) % 32;
            model_n++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load_all();
        for (int i = 0; i < 32; i++) begin
            ld_en = 1'b1; ld_addr = 5'(i); ld_data = 8'(prog[i]);
            @(negedge clk);
        end
        ld_en = 1'b0;
    endtask

    task automatic read_cell(input int addr, output int val);
        rd_addr = 5'(addr);
        @(negedge clk);
        val = rd_data;
    endtask

    // Pulse start and count rising edges until halted (R11).
    task automatic run(input bit disturb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        edges = 1;
        while (!halted && edges < 20000) begin
            if (disturb && edges == 10) begin
                start = 1'b1; ld_en = 1'b1; ld_addr = 5'd28; ld_data = 8'd77;
            end else begin
                start = 1'b0; ld_en = 1'b0;
            end
            @(negedge clk);
            edges++;
        end
        start = 1'b0; ld_en = 1'b0;
    endtask

    task automatic compare_mem(input string tag);
        int v;
        int bad = 0;
        for (int i = 0; i < 32; i++) begin
            read_cell(i, v);
            if (v != model[i]) begin
                bad++;
                check(0, $sformatf("%s cell %0d", tag, i), v, model[i]);
            end
        end
        if (bad == 0) check(1, tag, 0, 0);
    endtask

    initial begin
        #800000;
        wd_expired = 1;
    end

    initial begin : main
        int v;
        do_reset();
        // R9: reset state
        check(halted == 1'b0, "R9 halted after reset", halted, 0);
        check(instr_count == 0, "R9 count after reset", instr_count, 0);

        // R8: load then read back before start
        for (int i = 0; i < 32; i++) prog[i] = (i * 37 + 11) & 255;
        load_all();
        read_cell(13, v);
        check(v == ((13 * 37 + 11) & 255), "R8 read port before start", v, (13 * 37 + 11) & 255);

        // Table: one subtraction, then a marker that reveals the branch (R1, R2, R11)
        for (int k = 0; k < 10; k++) begin
            int exp_r;
            bit exp_br;
            for (int i = 0; i < 32; i++) prog[i] = 0;
            prog[0] = 20; prog[1] = 21; prog[2] = 9;
            prog[3] = 25; prog[4] = 26; prog[5] = 31;
            prog[9] = 25; prog[10] = 27; prog[11] = 31;
            prog[20] = VEC[k][15:8]; prog[21] = VEC[k][7:0]; prog[25] = 1;
            exp_r = (prog[21] - prog[20]) & 255;
            exp_br = (exp_r == 0) || (exp_r >= 128);
            run_model();
            do_reset();
            load_all();
            run(1'b0);
            check(edges == 1 + 7 * 2, "R11 halt timing", edges, 15);
            check(instr_count == 2, "R6 count two instrs", instr_count, 2);
            read_cell(21, v);
            check(v == exp_r, "R1 difference in cell B", v, exp_r);
            read_cell(exp_br ? 27 : 26, v);
            check(v == 255, "R2 branch path marker", v, 255);
            read_cell(exp_br ? 26 : 27, v);
            check(v == 0, "R2 untaken path untouched", v, 0);
        end

        // R4: operand bytes with high bits set
        for (int i = 0; i < 32; i++) prog[i] = 0;
        prog[0] = 52; prog[1] = 53; prog[2] = 200;
        prog[3] = 22; prog[4] = 22; prog[5] = 63;
        prog[20] = 1; prog[21] = 5;
        run_model();
        do_reset(); load_all(); run(1'b0);
        read_cell(21, v);
        check(v == 4, "R4 low five address bits", v, 4);
        check(instr_count == 2, "R4 C=63 halts at 31", instr_count, 2);

        // R5, R7, R10: self-modifying walking eraser with disturbances
        for (int i = 0; i < 32; i++) prog[i] = 0;
        prog[0] = 24; prog[1] = 24; prog[2] = 3;
        prog[3] = 19; prog[4] = 0;  prog[5] = 6;
        prog[6] = 19; prog[7] = 1;  prog[8] = 9;
        prog[9] = 20; prog[10] = 21; prog[11] = 15;
        prog[12] = 18; prog[13] = 18; prog[14] = 0;
        prog[15] = 18; prog[16] = 18; prog[17] = 31;
        prog[19] = 255; prog[20] = 1; prog[21] = 4;
        prog[24] = 7; prog[25] = 99; prog[26] = 123; prog[27] = 200;
        run_model();
        do_reset(); load_all(); run(1'b1);
        check(edges == 1 + 7 * model_n, "R10 start while running ignored", edges, 1 + 7 * model_n);
        check(instr_count == model_n, "R6 count walk program", instr_count, model_n);
        compare_mem("R5 self-modifying final image");
        read_cell(28, v);
        check(v == 0, "R7 load while running ignored", v, 0);

        // R3: start and load while halted have no effect
        start = 1'b1; ld_en = 1'b1; ld_addr = 5'd24; ld_data = 8'd9;
        @(negedge clk);
        start = 1'b0; ld_en = 1'b0;
        repeat (20) @(negedge clk);
        check(halted == 1'b1, "R3 halt flag sticky", halted, 1);
        check(instr_count == model_n, "R3 count frozen when halted", instr_count, model_n);
        read_cell(24, v);
        check(v == model[24], "R7 load while halted ignored", v, model[24]);

        // R9: reset clears halt and count
        do_reset();
        check(halted == 1'b0 && instr_count == 0, "R9 reset after halt", instr_count, 0);

        if (wd_expired) check(0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (wd_expired);
        check(0, "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule